// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port with Address Override

This block controls four general-purpose pins for a peripheral bus. Software reaches five registers through a small synchronous bus:
- a direction register that can only be written,
- an output data latch,
- a read-only pin-level view,
- a pull-up enable,
- an open-drain enable.

For each pin the block produces an output-enable, an output value and a pull-up enable, which go to the pad.

When the chip runs with an external bus (the expanded mode input is high), each address-enable bit hands its pin to the external address bus. Such a pin then drives the supplied address bit whatever its direction bit holds.

Two standby inputs change the behaviour.
- **Hardware standby** clears the direction bits, blocks writes and releases every pad.
- **Software standby** keeps all register contents and blocks writes. A hold-control input decides how address pins behave. They either keep driving the address value captured just before standby, or they float.

Top module: `gpio_port`

## Requirements
- R1: After the active-low asynchronous reset, the direction, data, pull-up and open-drain registers are all 0. Every pad output-enable and pull-up enable is 0. A read of the data, pull-up or open-drain register returns 8'hF0: the filler 8'hF0 in bits 7..4 and 0 in bits 3..0.
- R2: Register offsets are: 0 direction, 1 data, 2 pin, 3 pull-up, 4 open-drain. A read of the direction register always returns the filler 8'hF0, whatever was written. In every register, bits 7..4 read as the filler nibble 4'hF and writes to them are dropped. Unused offsets read 8'hF0.
- R3: A write takes effect at the next clock edge. For a pin that is not an address pin, direction bit 1 makes it an output driving the data bit with output-enable 1. Direction bit 0 gives output-enable 0 and output value 0. Whenever output-enable is 0, the output value is 0.
- R4: For an output pin with its open-drain bit set, a data bit of 0 drives 0 with output-enable 1. A data bit of 1 releases the pin (output-enable 0).
- R5: The pull-up enable of a pin equals its pull-up bit only when the pin is an input and not an address pin. Otherwise it is 0.
- R6: A read of the pin register (offset 2) gives, per bit, the data latch for output pins. For input and address pins it gives the pad level through a two-flop synchronizer: a level change shows up after the second clock edge and not after the first.
- R7: With expanded mode high and its address-enable bit set, a pin drives its address bit with output-enable 1, whatever its direction bit holds. With expanded mode low, the address-enable bits have no effect.
- R8: While hardware standby is high:
  - the direction bits are cleared;
  - bus writes are ignored;
  - all output-enables and pull-up enables are 0;
  - the data, pull-up and open-drain registers keep their values.
- R9: While software standby is high, all registers keep their values, bus writes are ignored, and pins that are not address pins keep their configured drive.
- R10: In software standby, address pins keep driving the address value sampled at the last clock edge before standby when the hold input is 1. They float (output-enable 0) when the hold input is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from offset) |
| mode_expanded | input | 1 | External-bus operating mode |
| addr_en | input | 4 | Per-pin address-output enables |
| addr_val | input | 4 | Address bits from the bus generator |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| addr_hold | input | 1 | 1 = address pins hold in software standby, 0 = float |
| pin_in | input | 4 | Asynchronous pad levels |
| pad_oe | output | 4 | Per-pin output-enable |
| pad_out | output | 4 | Per-pin output value |
| pad_pu | output | 4 | Per-pin pull-up enable |

## Verification
Random register contents are crossed with random mode and address-enable values. This separates the three pin roles: address, push-pull or open-drain output, and input with or without pull-up. It also shows whether the address override really ignores the direction bit.

Directed patterns handle the rest. Writing all ones to the direction register and then reading it back separates the write-only register from an ordinary one. A pin step read after one and after two edges pins down the synchronizer depth. Standby entries with the hold input at each level, with the address changing during standby, separate a held snapshot from a live address and from a float.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DIR  = 3'd0,
        OFS_DATA = 3'd1,
        OFS_PIN  = 3'd2,
        OFS_PULL = 3'd3,
        OFS_ODE  = 3'd4
    } reg_ofs_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int          W       = 4,
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  RD_FILL = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [W-1:0]      pin_sync,
    input  logic [W-1:0]      is_addr,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      dout_q,
    output logic [W-1:0]      pull_q,
    output logic [W-1:0]      ode_q
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] pull;
        logic [W-1:0] ode;
    } regs_t;

    localparam logic [DATA_W-1:0] FILL = DATA_W'(RD_FILL);

    regs_t        st_d, st_q;
    logic         wr_ok;
    logic [W-1:0] pin_view;
    logic         unused_wr_hi;

    assign wr_ok        = bus_sel & bus_wr & ~hw_stby & ~sw_stby;
    assign unused_wr_hi = ^bus_wdata[DATA_W-1:W];

    always_comb begin
        st_d = st_q;
        if (hw_stby) begin
            st_d.dir = '0;
        end else if (wr_ok) begin
            case (reg_ofs_e'(bus_addr))
                OFS_DIR:  st_d.dir  = bus_wdata[W-1:0];
                OFS_DATA: st_d.dout = bus_wdata[W-1:0];
                OFS_PULL: st_d.pull = bus_wdata[W-1:0];
                OFS_ODE:  st_d.ode  = bus_wdata[W-1:0];
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            pin_view[i] = (st_q.dir[i] & ~is_addr[i]) ? st_q.dout[i] : pin_sync[i];
        end
    end

    always_comb begin
        bus_rdata = FILL;
        case (reg_ofs_e'(bus_addr))
            OFS_DATA: bus_rdata[W-1:0] = st_q.dout;
            OFS_PIN:  bus_rdata[W-1:0] = pin_view;
            OFS_PULL: bus_rdata[W-1:0] = st_q.pull;
            OFS_ODE:  bus_rdata[W-1:0] = st_q.ode;
            default:  bus_rdata = FILL;
        endcase
    end

    assign dir_q  = st_q.dir;
    assign dout_q = st_q.dout;
    assign pull_q = st_q.pull;
    assign ode_q  = st_q.ode;
endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_expanded,
    input  logic [W-1:0] addr_en,
    input  logic [W-1:0] addr_val,
    input  logic         hw_stby,
    input  logic         sw_stby,
    input  logic         addr_hold,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] pull,
    input  logic [W-1:0] ode,
    output logic [W-1:0] is_addr,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    logic [W-1:0] snap_d, snap_q;
    logic [W-1:0] addr_src;

    assign is_addr  = mode_expanded ? addr_en : '0;
    assign snap_d   = sw_stby ? snap_q : addr_val;
    assign addr_src = sw_stby ? snap_q : addr_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = 1'b0;
            pad_out[i] = 1'b0;
            pad_pu[i]  = 1'b0;
            if (hw_stby) begin
                pad_oe[i] = 1'b0;
            end else if (is_addr[i]) begin
                if (!(sw_stby && !addr_hold)) begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = addr_src[i];
                end
            end else if (dir[i]) begin
                if (ode[i]) begin
                    pad_oe[i] = ~dout[i];
                end else begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = dout[i];
                end
            end else begin
                pad_pu[i] = pull[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int         PORT_W  = 4,
    parameter int         DATA_W  = 8,
    parameter int         SYNC_N  = 2,
    parameter logic [7:0] RD_FILL = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              mode_expanded,
    input  logic [PORT_W-1:0] addr_en,
    input  logic [PORT_W-1:0] addr_val,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              addr_hold,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu
);
    logic [PORT_W-1:0] pin_sync_w;
    logic [PORT_W-1:0] is_addr_w;
    logic [PORT_W-1:0] dir_w, dout_w, pull_w, ode_w;

    gpio_port_sync #(.W(PORT_W), .STAGES(SYNC_N)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync_w)
    );

    gpio_port_regs #(.W(PORT_W), .DATA_W(DATA_W), .RD_FILL(RD_FILL)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync_w),
        .is_addr   (is_addr_w),
        .dir_q     (dir_w),
        .dout_q    (dout_w),
        .pull_q    (pull_w),
        .ode_q     (ode_w)
    );

    gpio_port_pads #(.W(PORT_W)) pads_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_expanded (mode_expanded),
        .addr_en       (addr_en),
        .addr_val      (addr_val),
        .hw_stby       (hw_stby),
        .sw_stby       (sw_stby),
        .addr_hold     (addr_hold),
        .dir           (dir_w),
        .dout          (dout_w),
        .pull          (pull_w),
        .ode           (ode_w),
        .is_addr       (is_addr_w),
        .pad_oe        (pad_oe),
        .pad_out       (pad_out),
        .pad_pu        (pad_pu)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         hw_stby,
    input logic         sw_stby,
    input logic         addr_hold,
    input logic         mode_expanded,
    input logic [W-1:0] addr_en,
    input logic [W-1:0] addr_val,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] ode_q
);
    logic [W-1:0] ovr;
    assign ovr = mode_expanded ? addr_en : '0;

    // R8: hardware standby leaves the direction bits cleared
    a_r8_hw_clears_dir: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dir_q == '0));

    // R8: no drive and no pull-up during hardware standby
    a_r8_hw_pads_off: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> (pad_oe == '0 && pad_pu == '0));

    // R9: software standby retains the direction bits
    a_r9_sw_retains_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> (dir_q == $past(dir_q)));

    // R7: active address pins always drive the live address
    a_r7_addr_override: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_stby && !sw_stby) |-> (((pad_oe & ovr) == ovr) &&
                                    ((pad_out & ovr) == (addr_val & ovr))));

    // R10: float setting releases every address pin in software standby
    a_r10_float: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby && !addr_hold) |-> ((pad_oe & ovr) == '0));

    // R5: pull-up never on a driven or output-configured pin
    a_r5_pu_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0) && ((pad_pu & dir_q) == '0));

    // R4: open-drain output pins never drive a 1
    a_r4_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ode_q & dir_q & ~ovr) == '0));

    // R3: undriven pins present output value 0
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));
endmodule

bind gpio_port gpio_port_chk #(.W(PORT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_stby       (hw_stby),
    .sw_stby       (sw_stby),
    .addr_hold     (addr_hold),
    .mode_expanded (mode_expanded),
    .addr_en       (addr_en),
    .addr_val      (addr_val),
    .pad_oe        (pad_oe),
    .pad_out       (pad_out),
    .pad_pu        (pad_pu),
    .dir_q         (dir_w),
    .ode_q         (ode_w)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
    localparam int W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       mode_expanded = 1'b0;
    logic [W-1:0] addr_en = '0, addr_val = '0, pin_in = '0;
    logic       hw_stby = 1'b0, sw_stby = 1'b0, addr_hold = 1'b0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    int errors = 0;
    int checks = 0;

    logic [W-1:0] m_dir = '0, m_dout = '0, m_pull = '0, m_ode = '0, m_snap = '0;

    always #5 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_expanded(mode_expanded), .addr_en(addr_en), .addr_val(addr_val),
        .hw_stby(hw_stby), .sw_stby(sw_stby), .addr_hold(addr_hold),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    function automatic logic [3*W-1:0] exp_pads();
        logic [W-1:0] oe, o, pu;
        oe = '0; o = '0; pu = '0;
        for (int i = 0; i < W; i++) begin
            if (hw_stby) begin
                oe[i] = 1'b0;
            end else if (mode_expanded && addr_en[i]) begin
                if (!(sw_stby && !addr_hold)) begin
                    oe[i] = 1'b1;
                    o[i]  = sw_stby ? m_snap[i] : addr_val[i];
                end
            end else if (m_dir[i]) begin
                if (m_ode[i]) oe[i] = ~m_dout[i];
                else begin oe[i] = 1'b1; o[i] = m_dout[i]; end
            end else begin
                pu[i] = m_pull[i];
            end
        end
        return {oe, o, pu};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_pads(input string tag);
        #1;
        check(tag, {20'd0, pad_oe, pad_out, pad_pu}, {20'd0, exp_pads()});
    endtask

    task automatic tick();
        if (!sw_stby) m_snap = addr_val;
        @(posedge clk);
        #2;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (!hw_stby && !sw_stby) begin
            case (a)
                3'd0: m_dir  = d[W-1:0];
                3'd1: m_dout = d[W-1:0];
                3'd3: m_pull = d[W-1:0];
                3'd4: m_ode  = d[W-1:0];
                default: ;
            endcase
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();

        // R1 reset values
        check_pads("R1 pads after reset");
        bus_read(3'd1, rd); check("R1 data reset", rd, 8'hF0);
        bus_read(3'd3, rd); check("R1 pull reset", rd, 8'hF0);
        bus_read(3'd4, rd); check("R1 ode reset", rd, 8'hF0);

        // R2 write-only direction, reserved bits, unused offset
        bus_write(3'd0, 8'hFF);
        bus_read(3'd0, rd); check("R2 dir reads filler", rd, 8'hF0);
        bus_write(3'd1, 8'h5A);
        bus_read(3'd1, rd); check("R2 reserved bits filler", rd, 8'hFA);
        bus_read(3'd6, rd); check("R2 unused offset", rd, 8'hF0);
        check_pads("R3 all outputs after dir write");

        // R4 open drain
        bus_write(3'd4, 8'h03);
        check_pads("R4 open-drain pins");

        // R5 pull-ups on inputs only
        bus_write(3'd0, 8'h0C);
        bus_write(3'd3, 8'h0F);
        check_pads("R5 pull-up only on inputs");

        // R6 pin read path and synchronizer depth
        pin_in = 4'b0001;
        tick(); tick();
        bus_read(3'd2, rd); check("R6 pin read mix", rd, {4'hF, m_dout[3:2], 2'b01});
        pin_in = 4'b0010;
        tick();
        bus_read(3'd2, rd); check("R6 one edge still old", rd, {4'hF, m_dout[3:2], 2'b01});
        tick();
        bus_read(3'd2, rd); check("R6 two edges new level", rd, {4'hF, m_dout[3:2], 2'b10});

        // R7 override and single-chip ignore
        addr_en = 4'b0101; addr_val = 4'b0100; mode_expanded = 1'b0;
        check_pads("R7 addr_en ignored in single-chip mode");
        mode_expanded = 1'b1;
        check_pads("R7 override ignores direction");
        bus_read(3'd2, rd); check("R6 address pin reads pad", rd, {4'hF, m_dout[3], 1'b0, 1'b1, 1'b0});

        // R8 hardware standby
        bus_write(3'd0, 8'h0F);
        hw_stby = 1'b1;
        check_pads("R8 pads off in hw standby");
        tick();
        bus_write(3'd1, 8'h03);
        m_dir = '0;
        hw_stby = 1'b0;
        check_pads("R8 dir cleared after hw standby");
        bus_read(3'd1, rd); check("R8 data kept, write ignored", rd, 8'hFA);

        // R9 / R10 software standby with hold
        bus_write(3'd4, 8'h00);
        bus_write(3'd0, 8'h0C);
        addr_en = 4'b0011; addr_val = 4'b0010;
        tick();
        addr_hold = 1'b1; sw_stby = 1'b1; addr_val = 4'b0001;
        check_pads("R10 hold keeps snapshot");
        bus_write(3'd0, 8'h00);
        bus_write(3'd1, 8'h00);
        check_pads("R9 writes ignored, drive kept");
        addr_hold = 1'b0;
        check_pads("R10 float releases address pins");
        sw_stby = 1'b0;
        tick();
        bus_read(3'd1, rd); check("R9 data retained", rd, {4'hF, m_dout});
        check_pads("R9 direction retained after exit");

        // Random mix of roles
        for (int n = 0; n < 200; n++) begin
            bus_write(3'd0, 8'($urandom()));
            bus_write(3'd1, 8'($urandom()));
            bus_write(3'd3, 8'($urandom()));
            bus_write(3'd4, 8'($urandom()));
            mode_expanded = 1'($urandom());
            addr_en  = W'($urandom());
            addr_val = W'($urandom());
            check_pads("R3 R4 R5 R7 random mix");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule